// File: doc/BRIEF.md
# Field-Memory Read Sequencer

This block paces the read side of two field memories that feed a vertical reconstruction stage. It counts clocks and pixels from each horizontal reference edge, and it counts lines from each vertical reference edge. From these counts it drives a read enable, an output enable and a shared read reset for the two memories. It also gives a two-bit mode code to the downstream filters and an output-valid window that marks the active pixels of each line.

The interpolate, film and field-parity inputs are captured only on the rising edge of the vertical reference. A whole field therefore runs in one mode. In the three single-path modes, the active lines of a field are split into a first block that memory A supplies and a second block that memory B supplies. The number of lines skipped before the first block depends on the field parity. In the multi-picture bypass mode, memory A streams continuously and a read reset is issued at a fixed clock offset in every line.

The block runs on the fast clock. A pixel enable at half rate advances the pixel counter. All offsets, lengths and line counts are parameters.

Top module: `fm_read_seq`

## Requirements
- R1: On the clock edge that sees the vertical reference rise, mode_o is loaded with {film_i, interp_i}. The codes are 0 = standard bypass, 1 = camera reconstruction, 2 = multi-picture bypass and 3 = film reconstruction. The new code is visible after that edge.
- R2: Changes on interp_i, film_i and even_i at any other time have no effect on mode_o, on even_o or on the read pattern until the next vertical reference rise.
- R3: even_o holds the even_i value captured at the last vertical reference rise (1 = even field, 0 = odd field).
- R4: On a line that reads memory A or B, that memory's read enable is high from RD_DLY clocks after the edge that detects the horizontal reference rise, and it stays high for RD_LEN clocks.
- R5: Lines are numbered from 1 at the first horizontal reference rise after a vertical reference. With SKIP = FIRST_SKIP in an odd field and SECOND_SKIP in an even field, memory A is read on lines SKIP+1 to SKIP+HALF_A. Memory B is read on the next HALF_B lines.
- R6: oe_a_o and oe_b_o are high for the whole of the lines on which their memory is the selected source. They are never high together.
- R7: valid_o is high on reading lines while the pixel count since the horizontal reference rise lies in [VALID_DLY, VALID_DLY + RD_LEN/2). Only cycles with pix_en_i high advance that count.
- R8: In multi-picture bypass, rd_en_a_o and oe_a_o stay high and memory B stays idle. rd_rst_o pulses for one clock when the clock count reaches RST_DLY on every line, and valid_o follows the R7 window on every line.
- R9: In the three other modes, rd_rst_o pulses for exactly one clock right after the vertical reference rise is detected.
- R10: During and after reset, all outputs are low and mode_o is 0 until the first vertical reference. Horizontal references seen before that produce no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_en_i | input | 1 | Half-rate pixel enable |
| href_i | input | 1 | Horizontal reference pulse |
| vref_i | input | 1 | Vertical reference pulse |
| interp_i | input | 1 | Interpolate request |
| film_i | input | 1 | Film request |
| even_i | input | 1 | Field parity, 1 = even |
| rd_en_a_o | output | 1 | Read enable, memory A |
| rd_en_b_o | output | 1 | Read enable, memory B |
| oe_a_o | output | 1 | Output enable, memory A |
| oe_b_o | output | 1 | Output enable, memory B |
| rd_rst_o | output | 1 | Read reset, shared by both memories |
| mode_o | output | 2 | Latched mode code |
| even_o | output | 1 | Retimed field parity |
| valid_o | output | 1 | Output-valid window |

## Verification
The bench runs whole fields in each of the four modes, with both parities, on shortened parameters. It compares every clock of every line against a model built from the requirements. An odd field against an even field tells the two skip counts apart. The lines around the A/B boundary show whether the split happens on the right line, and the final idle lines show where reading stops. After each vertical reference, the bench inverts the mode and parity inputs to prove they are held. Horizontal references before the first vertical reference show that the block stays quiet, and a multi-picture field separates the per-line reset and continuous read from the field-level reset.

// File: rtl/fmrs_pkg.sv
package fmrs_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'b00,
    MODE_CAM  = 2'b01,
    MODE_PIP  = 2'b10,
    MODE_FILM = 2'b11
  } mode_e;
endpackage

// File: rtl/fmrs_mode_latch.sv
module fmrs_mode_latch
  import fmrs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vref_rise_i,
  input  logic  interp_i,
  input  logic  film_i,
  input  logic  even_i,
  output mode_e mode_o,
  output logic  even_o,
  output logic  seen_o,
  output logic  vrst_o
);
  mode_e mode_q;
  logic  even_q, seen_q, vrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BYP;
      even_q <= 1'b0;
      seen_q <= 1'b0;
      vrst_q <= 1'b0;
    end else if (vref_rise_i) begin
      mode_q <= mode_e'({film_i, interp_i});
      even_q <= even_i;
      seen_q <= 1'b1;
      vrst_q <= !(film_i && !interp_i);  // no field-level reset in multi-picture
    end else begin
      vrst_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign even_o = even_q;
  assign seen_o = seen_q;
  assign vrst_o = vrst_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vref_rise_i |=> $stable(mode_q) && $stable(even_q)); // R2
  AST_VRST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrst_q |=> !vrst_q); // R9
endmodule

// File: rtl/fmrs_line_ctr.sv
module fmrs_line_ctr #(
  parameter int FIRST_SKIP  = 20,
  parameter int SECOND_SKIP = 19,
  parameter int HALF_A      = 146,
  parameter int HALF_B      = 145
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic href_rise_i,
  input  logic vref_rise_i,
  input  logic seen_i,
  input  logic even_i,
  output logic sel_a_o,
  output logic sel_b_o,
  output logic any_line_o
);
  localparam int MAX_SKIP = (FIRST_SKIP > SECOND_SKIP) ? FIRST_SKIP : SECOND_SKIP;
  localparam int LN_W     = $clog2(MAX_SKIP + HALF_A + HALF_B + 2) + 1;
  localparam logic [LN_W-1:0] LN_MAX   = '1;
  localparam logic [LN_W-1:0] SKIP_ODD = LN_W'(FIRST_SKIP);
  localparam logic [LN_W-1:0] SKIP_EVN = LN_W'(SECOND_SKIP);
  localparam logic [LN_W-1:0] LEN_A    = LN_W'(HALF_A);
  localparam logic [LN_W-1:0] LEN_AB   = LN_W'(HALF_A + HALF_B);

  logic [LN_W-1:0] ln_q, skip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ln_q <= '0;
    else if (vref_rise_i)                  ln_q <= '0;
    else if (href_rise_i && ln_q != LN_MAX) ln_q <= ln_q + LN_W'(1);
  end

  assign skip       = even_i ? SKIP_EVN : SKIP_ODD;
  assign sel_a_o    = seen_i && (ln_q > skip) && (ln_q <= skip + LEN_A);
  assign sel_b_o    = seen_i && (ln_q > skip + LEN_A) && (ln_q <= skip + LEN_AB);
  assign any_line_o = seen_i && (ln_q != '0);

  AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_rise_i |=> ln_q == '0); // R5
  AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_a_o && sel_b_o)); // R6
endmodule

// File: rtl/fmrs_pix_tmr.sv
module fmrs_pix_tmr #(
  parameter int LINE_PIX  = 1024,
  parameter int RD_DLY    = 127,
  parameter int RD_LEN    = 1680,
  parameter int VALID_DLY = 80,
  parameter int RST_DLY   = 2016
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic href_rise_i,
  input  logic pix_en_i,
  output logic rd_win_o,
  output logic vld_win_o,
  output logic rst_hit_o
);
  localparam int CYC_W = $clog2(2 * LINE_PIX) + 1;
  localparam int PX_W  = $clog2(LINE_PIX) + 1;
  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [PX_W-1:0]  PX_MAX  = '1;
  localparam logic [CYC_W-1:0] RD_ON   = CYC_W'(RD_DLY);
  localparam logic [CYC_W-1:0] RD_OFF  = CYC_W'(RD_DLY + RD_LEN);
  localparam logic [CYC_W-1:0] RST_AT  = CYC_W'(RST_DLY);
  localparam logic [PX_W-1:0]  V_ON    = PX_W'(VALID_DLY);
  localparam logic [PX_W-1:0]  V_OFF   = PX_W'(VALID_DLY + RD_LEN / 2);

  logic [CYC_W-1:0] cyc_q;
  logic [PX_W-1:0]  px_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= CYC_MAX;
      px_q  <= PX_MAX;
    end else if (href_rise_i) begin
      cyc_q <= '0;
      px_q  <= '0;
    end else begin
      if (cyc_q != CYC_MAX)             cyc_q <= cyc_q + CYC_W'(1);
      if (pix_en_i && px_q != PX_MAX)   px_q  <= px_q + PX_W'(1);
    end
  end

  assign rd_win_o  = (cyc_q >= RD_ON) && (cyc_q < RD_OFF);
  assign vld_win_o = (px_q >= V_ON) && (px_q < V_OFF);
  assign rst_hit_o = (cyc_q == RST_AT);

  AST_CYC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    href_rise_i |=> cyc_q == '0 && px_q == '0); // R4
  AST_PX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !href_rise_i && pix_en_i && px_q != PX_MAX |=> px_q == $past(px_q) + PX_W'(1)); // R7
endmodule

// File: rtl/fm_read_seq.sv
module fm_read_seq
  import fmrs_pkg::*;
#(
  parameter int LINE_PIX    = 1024,
  parameter int RD_DLY      = 127,
  parameter int RD_LEN      = 1680,
  parameter int VALID_DLY   = 80,
  parameter int RST_DLY     = 2016,
  parameter int FIRST_SKIP  = 20,
  parameter int SECOND_SKIP = 19,
  parameter int HALF_A      = 146,
  parameter int HALF_B      = 145
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_en_i,
  input  logic       href_i,
  input  logic       vref_i,
  input  logic       interp_i,
  input  logic       film_i,
  input  logic       even_i,
  output logic       rd_en_a_o,
  output logic       rd_en_b_o,
  output logic       oe_a_o,
  output logic       oe_b_o,
  output logic       rd_rst_o,
  output logic [1:0] mode_o,
  output logic       even_o,
  output logic       valid_o
);
  logic  href_q, vref_q, href_rise, vref_rise;
  mode_e mode;
  logic  field_even, seen, vrst, pip;
  logic  sel_a, sel_b, any_line, rd_win, vld_win, rst_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      href_q <= 1'b0;
      vref_q <= 1'b0;
    end else begin
      href_q <= href_i;
      vref_q <= vref_i;
    end
  end

  assign href_rise = href_i && !href_q;
  assign vref_rise = vref_i && !vref_q;

  fmrs_mode_latch u_mode (
    .clk_i, .rst_ni,
    .vref_rise_i (vref_rise),
    .interp_i, .film_i, .even_i,
    .mode_o      (mode),
    .even_o      (field_even),
    .seen_o      (seen),
    .vrst_o      (vrst)
  );

  fmrs_line_ctr #(
    .FIRST_SKIP (FIRST_SKIP), .SECOND_SKIP (SECOND_SKIP),
    .HALF_A (HALF_A), .HALF_B (HALF_B)
  ) u_line (
    .clk_i, .rst_ni,
    .href_rise_i (href_rise),
    .vref_rise_i (vref_rise),
    .seen_i      (seen),
    .even_i      (field_even),
    .sel_a_o     (sel_a),
    .sel_b_o     (sel_b),
    .any_line_o  (any_line)
  );

  fmrs_pix_tmr #(
    .LINE_PIX (LINE_PIX), .RD_DLY (RD_DLY), .RD_LEN (RD_LEN),
    .VALID_DLY (VALID_DLY), .RST_DLY (RST_DLY)
  ) u_tmr (
    .clk_i, .rst_ni,
    .href_rise_i (href_rise),
    .pix_en_i,
    .rd_win_o    (rd_win),
    .vld_win_o   (vld_win),
    .rst_hit_o   (rst_hit)
  );

  assign pip       = (mode == MODE_PIP);
  assign rd_en_a_o = pip ? seen : (sel_a && rd_win);
  assign rd_en_b_o = !pip && sel_b && rd_win;
  assign oe_a_o    = pip ? seen : sel_a;
  assign oe_b_o    = !pip && sel_b;
  assign valid_o   = (pip ? any_line : (sel_a || sel_b)) && vld_win;
  assign rd_rst_o  = vrst || (pip && any_line && rst_hit);
  assign mode_o    = mode;
  assign even_o    = field_even;

  AST_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_a_o && oe_b_o)); // R6
  AST_PIP_B_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> !rd_en_b_o && !oe_b_o); // R8
  AST_QUIET_BEFORE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> !rd_en_a_o && !rd_en_b_o && !valid_o && !rd_rst_o); // R10
endmodule

// File: tb/fm_read_seq_test.sv
`timescale 1ns/1ps
module fm_read_seq_test;
  localparam int LINE_PIX = 64, RD_DLY = 7, RD_LEN = 80, VALID_DLY = 5, RST_DLY = 100;
  localparam int FS = 3, SS = 2, HA = 4, HB = 3;
  localparam int LINE_CYC = 2 * LINE_PIX, HREF_CYC = 6;

  logic clk = 1'b0, rst_ni = 1'b0, pix_en = 1'b0;
  logic href = 1'b0, vref = 1'b0, interp = 1'b0, film = 1'b0, even = 1'b0;
  logic rd_a, rd_b, oe_a, oe_b, rrst, even_o, valid;
  logic [1:0] mode_o;

  int n_chk = 0, n_fail = 0;
  logic [1:0] cur_mode = 2'b00;
  logic cur_even = 1'b0, started = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) pix_en <= ~pix_en;

  fm_read_seq #(
    .LINE_PIX (LINE_PIX), .RD_DLY (RD_DLY), .RD_LEN (RD_LEN), .VALID_DLY (VALID_DLY),
    .RST_DLY (RST_DLY), .FIRST_SKIP (FS), .SECOND_SKIP (SS), .HALF_A (HA), .HALF_B (HB)
  ) uut (
    .clk_i (clk), .rst_ni (rst_ni), .pix_en_i (pix_en), .href_i (href), .vref_i (vref),
    .interp_i (interp), .film_i (film), .even_i (even),
    .rd_en_a_o (rd_a), .rd_en_b_o (rd_b), .oe_a_o (oe_a), .oe_b_o (oe_b),
    .rd_rst_o (rrst), .mode_o (mode_o), .even_o (even_o), .valid_o (valid)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp);
    end
  endtask

  // Vertical reference with new mode; inputs then inverted to show they are held.
  task automatic do_vref(logic [1:0] m, logic e);
    vref = 1'b1; film = m[1]; interp = m[0]; even = e;
    @(posedge clk); @(negedge clk);
    cur_mode = m; cur_even = e; started = 1'b1;
    check("R1", "mode", mode_o, m);
    check("R3", "even", even_o, e);
    check("R9", "field reset", rrst, (m != 2'b10) ? 1 : 0);
    vref = 1'b0; film = ~m[1]; interp = ~m[0]; even = ~e;
    @(posedge clk); @(negedge clk);
    check("R9", "field reset width", rrst, 0);
    repeat (2) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_line(int n);
    int skip, px;
    bit pip, sa, sb, win, vw;
    skip = cur_even ? SS : FS;
    pip  = started && (cur_mode == 2'b10);
    sa   = started && !pip && n > skip && n <= skip + HA;
    sb   = started && !pip && n > skip + HA && n <= skip + HA + HB;
    px   = 0;
    href = 1'b1;
    @(posedge clk);
    for (int k = 0; k < LINE_CYC; k++) begin
      if (k > 0) begin
        @(posedge clk);
        if (pix_en) px++;
      end
      @(negedge clk);
      win = (k >= RD_DLY) && (k < RD_DLY + RD_LEN);
      vw  = (px >= VALID_DLY) && (px < VALID_DLY + RD_LEN / 2);
      if (pip) begin
        check("R8", "rd_a pip", rd_a, 1);
        check("R8", "rd_b pip", rd_b, 0);
        check("R8", "oe_a pip", oe_a, 1);
        check("R8", "oe_b pip", oe_b, 0);
        check("R8", "rst pip", rrst, (k == RST_DLY) ? 1 : 0);
        check("R8", "valid pip", valid, vw ? 1 : 0);
      end else begin
        check(started ? "R4" : "R10", "rd_a", rd_a, (sa && win) ? 1 : 0);
        check(started ? "R5" : "R10", "rd_b", rd_b, (sb && win) ? 1 : 0);
        check(started ? "R6" : "R10", "oe_a", oe_a, sa ? 1 : 0);
        check(started ? "R6" : "R10", "oe_b", oe_b, sb ? 1 : 0);
        check(started ? "R7" : "R10", "valid", valid, ((sa || sb) && vw) ? 1 : 0);
        check(started ? "R9" : "R10", "rst idle", rrst, 0);
      end
      check("R2", "mode held", mode_o, cur_mode);
      check("R2", "even held", even_o, cur_even);
      if (k == HREF_CYC - 1) href = 1'b0;
    end
  endtask

  task automatic run_field(logic [1:0] m, logic e, int lines);
    do_vref(m, e);
    for (int n = 1; n <= lines; n++) do_line(n);
  endtask

  task automatic test_reset();
    check("R10", "rd_a rst", rd_a, 0);
    check("R10", "oe_a rst", oe_a, 0);
    check("R10", "valid rst", valid, 0);
    check("R10", "mode rst", mode_o, 0);
    check("R10", "rrst rst", rrst, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    do_line(FS + 1);  // before any vertical reference: must stay quiet
    do_line(FS + 2);
  endtask

  task automatic test_bypass_odd();  run_field(2'b00, 1'b0, FS + HA + HB + 2); endtask
  task automatic test_bypass_even(); run_field(2'b00, 1'b1, SS + HA + HB + 2); endtask
  task automatic test_camera();      run_field(2'b01, 1'b1, SS + HA + HB + 1); endtask
  task automatic test_film();        run_field(2'b11, 1'b0, FS + HA + HB + 1); endtask
  task automatic test_pip();         run_field(2'b10, 1'b0, 3);                endtask
  task automatic test_back_to_cam(); run_field(2'b01, 1'b0, FS + HA + 1);      endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL R10 watchdog: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_bypass_odd();
    test_bypass_even();
    test_camera();
    test_film();
    test_pip();
    test_back_to_cam();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule